// File: doc/BRIEF.md
# Programmable FIFO Level Flags

This block produces the two threshold flags of a dual-clock FIFO: an active-low almost-empty indication in the read clock domain and an active-low almost-full indication in the write clock domain. Each flag compares the FIFO fill level against a programmable offset. The FIFO pointers are inputs. In each domain the block receives the local pointer and a copy of the remote pointer that has already been synchronized. Pointers are binary and carry one extra wrap bit above the address.

Both offsets come out of reset at a default of 7. The mode is captured while reset is held. If the offset-select line is low during reset, the block runs in programmable mode. In that mode, holding offset-select low turns a write-enable cycle into an offset store and a read-enable cycle into an offset read-back. Successive accesses alternate between the empty offset and the full offset. If offset-select is high during reset, the block runs in dual-enable mode. There, offset-select acts only as a second, active-high write qualifier and offsets can never change. The block also returns the qualified FIFO write and read strobes, so that offset traffic never moves data.

Top module: `fifo_level_flags`

## Requirements
- R1: The reset is synchronous and active low. At each clock edge with `rst_n` low, `almost_empty_n` goes to 0, `almost_full_n` goes to 1, and `ofs_rdata` goes to 0.
- R2: At each `rclk` edge, `almost_empty_n` is driven to 0 if the stored word count is at or below the empty offset, and to 1 otherwise. The stored word count is `wr_ptr_rsync - rd_ptr` modulo 2^(AW+1).
- R3: At each `wclk` edge, `almost_full_n` is driven to 0 if the free space is at or below the full offset, and to 1 otherwise. The free space is 2^AW minus `wr_ptr - rd_ptr_wsync` (taken modulo 2^(AW+1)).
- R4: After reset, both the empty offset and the full offset equal 7 (parameter `DEF_OFS`).
- R5: The value of `ofs_sel_n` during reset selects the mode. A 0 selects programmable mode and a 1 selects dual-enable mode. In dual-enable mode, `ofs_rdata` never changes after reset.
- R6: In programmable mode, each `wclk` edge with `ofs_sel_n`=0 and `wr_en`=1 stores `ofs_wdata` into the next offset. The order is empty offset, then full offset, then back to the empty offset.
- R7: In programmable mode, each `rclk` edge with `ofs_sel_n`=0 and `rd_en`=1 puts the next offset on `ofs_rdata`. The order is empty, then full, then wrapping, and the value is visible right after that edge. At all other edges `ofs_rdata` holds its value.
- R8: A clock edge with `ofs_sel_n`=1 returns that domain's sequence position to the empty offset.
- R9: `fifo_wr_ok` = `wr_en` AND `ofs_sel_n` in both modes. `fifo_rd_ok` = `rd_en` AND `ofs_sel_n` in programmable mode, and = `rd_en` in dual-enable mode.
- R10: In dual-enable mode, write cycles with `ofs_sel_n`=0 leave both offsets unchanged. This is seen through the flag thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Synchronous active-low reset, seen by both domains |
| ofs_sel_n | input | 1 | Offset access select (low); captured at reset as the mode strap |
| wr_en | input | 1 | Write enable |
| rd_en | input | 1 | Read enable |
| wr_ptr | input | AW+1 | Write pointer, write domain |
| rd_ptr_wsync | input | AW+1 | Read pointer synchronized into the write domain |
| rd_ptr | input | AW+1 | Read pointer, read domain |
| wr_ptr_rsync | input | AW+1 | Write pointer synchronized into the read domain |
| ofs_wdata | input | AW | Offset value to store |
| ofs_rdata | output | AW | Offset read-back value |
| almost_empty_n | output | 1 | Almost-empty flag, active low, read domain |
| almost_full_n | output | 1 | Almost-full flag, active low, write domain |
| fifo_wr_ok | output | 1 | Qualified FIFO data write strobe |
| fifo_rd_ok | output | 1 | Qualified FIFO data read strobe |

## Verification
The level assertions assume that each pair of pointers is never more than 2^AW apart. They also assume that the offsets change only while the read side is not reading them back, because the read domain uses the write-domain offset registers directly. The stimulus meets both conditions. It sets pointer pairs to levels between 0 and 2^AW, and it places some of those levels across the pointer wrap. It performs all offset stores before any read-back or flag check that depends on them. Clocks run at the same rate with a phase offset, and inputs change well away from either edge.

// File: rtl/fifo_flag_pkg.sv
package fifo_flag_pkg;

    // Which offset register the access sequencer currently addresses.
    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } ofs_slot_e;

    function automatic ofs_slot_e next_slot(input ofs_slot_e cur);
        return (cur == SLOT_EMPTY) ? SLOT_FULL : SLOT_EMPTY;
    endfunction

endpackage

// File: rtl/ofs_seq.sv
module ofs_seq
    import fifo_flag_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sel_n,
    input  logic      step,
    output ofs_slot_e slot
);

    typedef struct packed {
        ofs_slot_e slot;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n || sel_n) begin
            st_d.slot = SLOT_EMPTY;
        end else if (step) begin
            st_d.slot = next_slot(st_q.slot);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign slot = st_q.slot;

    // R8
    seq_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> (slot == SLOT_EMPTY));

    // R6
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !sel_n) |=> (slot != $past(slot)));

endmodule

// File: rtl/flag_wr_side.sv
module flag_wr_side
    import fifo_flag_pkg::*;
#(
    parameter int AW      = 4,
    parameter int DEF_OFS = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_n,
    input  logic          wr_en,
    input  logic [AW:0]   wr_ptr,
    input  logic [AW:0]   rd_ptr_sync,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] empty_ofs,
    output logic [AW-1:0] full_ofs,
    output logic          almost_full_n,
    output logic          wr_ok
);

    localparam int            DEPTH   = 1 << AW;
    localparam logic [AW:0]   DEPTH_P = DEPTH[AW:0];
    localparam logic [AW-1:0] DEF_V   = DEF_OFS[AW-1:0];

    typedef struct packed {
        logic          prog;
        logic [AW-1:0] e_ofs;
        logic [AW-1:0] f_ofs;
        logic          af_n;
    } wr_state_t;

    wr_state_t   st_d, st_q;
    logic        load;
    logic [AW:0] used;
    logic [AW:0] free;
    ofs_slot_e   slot;

    ofs_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .sel_n (sel_n),
        .step  (load),
        .slot  (slot)
    );

    always_comb begin
        st_d = st_q;
        load = st_q.prog && !sel_n && wr_en;
        used = wr_ptr - rd_ptr_sync;
        free = DEPTH_P - used;
        if (!rst_n) begin
            st_d.prog  = !sel_n;
            st_d.e_ofs = DEF_V;
            st_d.f_ofs = DEF_V;
            st_d.af_n  = 1'b1;
        end else begin
            st_d.af_n = !(free <= {1'b0, st_q.f_ofs});
            if (load) begin
                if (slot == SLOT_EMPTY) begin
                    st_d.e_ofs = wdata;
                end else begin
                    st_d.f_ofs = wdata;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign empty_ofs     = st_q.e_ofs;
    assign full_ofs      = st_q.f_ofs;
    assign almost_full_n = st_q.af_n;
    assign wr_ok         = wr_en && sel_n;

    // R1
    af_reset_chk: assert property (@(posedge clk)
        !rst_n |=> almost_full_n);

    // R3
    full_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (used == DEPTH_P) |=> !almost_full_n);

    // R10
    offs_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.prog |=> ($stable(empty_ofs) && $stable(full_ofs)));

endmodule

// File: rtl/flag_rd_side.sv
module flag_rd_side
    import fifo_flag_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_n,
    input  logic          rd_en,
    input  logic [AW:0]   rd_ptr,
    input  logic [AW:0]   wr_ptr_sync,
    input  logic [AW-1:0] empty_ofs,
    input  logic [AW-1:0] full_ofs,
    output logic [AW-1:0] rdata,
    output logic          almost_empty_n,
    output logic          rd_ok
);

    typedef struct packed {
        logic          prog;
        logic [AW-1:0] rdata;
        logic          ae_n;
    } rd_state_t;

    rd_state_t   st_d, st_q;
    logic        fetch;
    logic [AW:0] used;
    ofs_slot_e   slot;

    ofs_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .sel_n (sel_n),
        .step  (fetch),
        .slot  (slot)
    );

    always_comb begin
        st_d  = st_q;
        fetch = st_q.prog && !sel_n && rd_en;
        used  = wr_ptr_sync - rd_ptr;
        if (!rst_n) begin
            st_d.prog  = !sel_n;
            st_d.rdata = '0;
            st_d.ae_n  = 1'b0;
        end else begin
            st_d.ae_n = !(used <= {1'b0, empty_ofs});
            if (fetch) begin
                st_d.rdata = (slot == SLOT_EMPTY) ? empty_ofs : full_ofs;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rdata          = st_q.rdata;
    assign almost_empty_n = st_q.ae_n;
    assign rd_ok          = st_q.prog ? (rd_en && sel_n) : rd_en;

    // R1
    ae_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (!almost_empty_n && (rdata == '0)));

    // R2
    empty_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr_sync == rd_ptr) |=> !almost_empty_n);

    // R7
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.prog && !sel_n && rd_en) |=> $stable(rdata));

endmodule

// File: rtl/fifo_level_flags.sv
module fifo_level_flags #(
    parameter int AW      = 4,
    parameter int DEF_OFS = 7
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          ofs_sel_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW:0]   wr_ptr,
    input  logic [AW:0]   rd_ptr_wsync,
    input  logic [AW:0]   rd_ptr,
    input  logic [AW:0]   wr_ptr_rsync,
    input  logic [AW-1:0] ofs_wdata,
    output logic [AW-1:0] ofs_rdata,
    output logic          almost_empty_n,
    output logic          almost_full_n,
    output logic          fifo_wr_ok,
    output logic          fifo_rd_ok
);

    logic [AW-1:0] empty_ofs;
    logic [AW-1:0] full_ofs;

    flag_wr_side #(
        .AW      (AW),
        .DEF_OFS (DEF_OFS)
    ) u_wr (
        .clk           (wclk),
        .rst_n         (rst_n),
        .sel_n         (ofs_sel_n),
        .wr_en         (wr_en),
        .wr_ptr        (wr_ptr),
        .rd_ptr_sync   (rd_ptr_wsync),
        .wdata         (ofs_wdata),
        .empty_ofs     (empty_ofs),
        .full_ofs      (full_ofs),
        .almost_full_n (almost_full_n),
        .wr_ok         (fifo_wr_ok)
    );

    flag_rd_side #(
        .AW (AW)
    ) u_rd (
        .clk            (rclk),
        .rst_n          (rst_n),
        .sel_n          (ofs_sel_n),
        .rd_en          (rd_en),
        .rd_ptr         (rd_ptr),
        .wr_ptr_sync    (wr_ptr_rsync),
        .empty_ofs      (empty_ofs),
        .full_ofs       (full_ofs),
        .rdata          (ofs_rdata),
        .almost_empty_n (almost_empty_n),
        .rd_ok          (fifo_rd_ok)
    );

endmodule

// File: tb/sim_fifo_level_flags.sv
`timescale 1ns/1ps
module sim_fifo_level_flags;

    localparam int AW = 4;

    logic          wclk = 1'b0;
    logic          rclk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ofs_sel_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW:0]   wr_ptr = '0;
    logic [AW:0]   rd_ptr_wsync = '0;
    logic [AW:0]   rd_ptr = '0;
    logic [AW:0]   wr_ptr_rsync = '0;
    logic [AW-1:0] ofs_wdata = '0;
    logic [AW-1:0] ofs_rdata;
    logic          almost_empty_n;
    logic          almost_full_n;
    logic          fifo_wr_ok;
    logic          fifo_rd_ok;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 wclk = ~wclk;
    initial begin
        #7;
        forever #10 rclk = ~rclk;
    end

    fifo_level_flags #(.AW(AW), .DEF_OFS(7)) u0 (
        .wclk           (wclk),
        .rclk           (rclk),
        .rst_n          (rst_n),
        .ofs_sel_n      (ofs_sel_n),
        .wr_en          (wr_en),
        .rd_en          (rd_en),
        .wr_ptr         (wr_ptr),
        .rd_ptr_wsync   (rd_ptr_wsync),
        .rd_ptr         (rd_ptr),
        .wr_ptr_rsync   (wr_ptr_rsync),
        .ofs_wdata      (ofs_wdata),
        .ofs_rdata      (ofs_rdata),
        .almost_empty_n (almost_empty_n),
        .almost_full_n  (almost_full_n),
        .fifo_wr_ok     (fifo_wr_ok),
        .fifo_rd_ok     (fifo_rd_ok)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic wtick();
        @(posedge wclk);
        #2;
    endtask

    task automatic rtick();
        @(posedge rclk);
        #2;
    endtask

    task automatic do_reset(input bit prog);
        rst_n = 1'b0;
        ofs_sel_n = prog ? 1'b0 : 1'b1;
        wr_en = 1'b0;
        rd_en = 1'b0;
        repeat (4) @(posedge wclk);
        @(negedge wclk);
        rst_n = 1'b1;
        ofs_sel_n = 1'b1;
        #1;
    endtask

    task automatic set_rlevel(input logic [AW:0] base, input int lvl);
        rd_ptr = base;
        wr_ptr_rsync = base + lvl[AW:0];
    endtask

    task automatic set_wlevel(input logic [AW:0] base, input int lvl);
        rd_ptr_wsync = base;
        wr_ptr = base + lvl[AW:0];
    endtask

    task automatic read_back(output int v);
        ofs_sel_n = 1'b0;
        rd_en = 1'b1;
        rtick();
        v = ofs_rdata;
    endtask

    task automatic end_access();
        ofs_sel_n = 1'b1;
        rd_en = 1'b0;
        wr_en = 1'b0;
        wtick();
        rtick();
    endtask

    task automatic t_reset();
        do_reset(1'b1);
        check("R1 almost_empty_n", almost_empty_n, 0);
        check("R1 almost_full_n", almost_full_n, 1);
        check("R1 ofs_rdata", ofs_rdata, 0);
    endtask

    task automatic t_defaults();
        int v;
        rtick();
        read_back(v);
        check("R4 default empty offset", v, 7);
        read_back(v);
        check("R4 default full offset", v, 7);
        end_access();
    endtask

    task automatic t_load();
        int v;
        wtick();
        ofs_sel_n = 1'b0;
        wr_en = 1'b1;
        ofs_wdata = 4'd3;
        wtick();
        ofs_wdata = 4'd5;
        wtick();
        ofs_wdata = 4'd9;
        wtick();
        wr_en = 1'b0;
        ofs_sel_n = 1'b1;
        wtick();
        rtick();
        read_back(v);
        check("R6 wrapped write into empty offset", v, 9);
        read_back(v);
        check("R6 full offset loaded", v, 5);
        read_back(v);
        check("R7 read-back wraps to empty offset", v, 9);
        ofs_sel_n = 1'b1;
        rd_en = 1'b0;
        rtick();
        rtick();
        check("R7 read-back holds when idle", ofs_rdata, 9);
    endtask

    task automatic t_seq_home();
        int v;
        wtick();
        ofs_sel_n = 1'b0;
        wr_en = 1'b1;
        ofs_wdata = 4'd4;
        wtick();
        ofs_sel_n = 1'b1;
        wr_en = 1'b0;
        wtick();
        ofs_sel_n = 1'b0;
        wr_en = 1'b1;
        ofs_wdata = 4'd6;
        wtick();
        end_access();
        read_back(v);
        check("R8 write sequence restarted at empty", v, 6);
        ofs_sel_n = 1'b1;
        rd_en = 1'b0;
        rtick();
        read_back(v);
        check("R8 read sequence restarted at empty", v, 6);
        read_back(v);
        check("R8 full offset untouched", v, 5);
        end_access();
    endtask

    task automatic t_almost_empty();
        set_rlevel(5'd28, 6);
        rtick(); rtick();
        check("R2 level at offset across wrap", almost_empty_n, 0);
        set_rlevel(5'd28, 7);
        rtick(); rtick();
        check("R2 level one above offset", almost_empty_n, 1);
        set_rlevel(5'd3, 0);
        rtick(); rtick();
        check("R2 empty", almost_empty_n, 0);
        set_rlevel(5'd20, 16);
        rtick(); rtick();
        check("R2 full FIFO", almost_empty_n, 1);
    endtask

    task automatic t_almost_full();
        set_wlevel(5'd30, 11);
        wtick(); wtick();
        check("R3 free space at offset", almost_full_n, 0);
        set_wlevel(5'd30, 10);
        wtick(); wtick();
        check("R3 free space one above offset", almost_full_n, 1);
        set_wlevel(5'd9, 16);
        wtick(); wtick();
        check("R3 full FIFO", almost_full_n, 0);
        set_wlevel(5'd9, 0);
        wtick(); wtick();
        check("R3 empty FIFO", almost_full_n, 1);
    endtask

    task automatic t_gate_prog();
        wtick();
        wr_en = 1'b1;
        rd_en = 1'b1;
        ofs_sel_n = 1'b1;
        #1;
        check("R9 write strobe passes", fifo_wr_ok, 1);
        check("R9 read strobe passes", fifo_rd_ok, 1);
        ofs_sel_n = 1'b0;
        #1;
        check("R9 write strobe blocked by offset select", fifo_wr_ok, 0);
        check("R5 R9 read strobe blocked in programmable mode", fifo_rd_ok, 0);
        ofs_sel_n = 1'b1;
        wr_en = 1'b0;
        rd_en = 1'b0;
        #1;
    endtask

    task automatic t_dual_enable();
        do_reset(1'b0);
        check("R1 almost_empty_n after dual-enable reset", almost_empty_n, 0);
        set_rlevel(5'd0, 7);
        rtick(); rtick();
        check("R4 default empty threshold", almost_empty_n, 0);
        set_rlevel(5'd0, 8);
        rtick(); rtick();
        check("R4 default empty threshold plus one", almost_empty_n, 1);
        wtick();
        ofs_sel_n = 1'b0;
        wr_en = 1'b1;
        rd_en = 1'b1;
        ofs_wdata = 4'd1;
        #1;
        check("R9 dual-enable write strobe needs select high", fifo_wr_ok, 0);
        check("R9 dual-enable read strobe ignores select", fifo_rd_ok, 1);
        wtick(); wtick(); wtick();
        rtick(); rtick();
        check("R5 no read-back in dual-enable mode", ofs_rdata, 0);
        ofs_sel_n = 1'b1;
        wr_en = 1'b0;
        rd_en = 1'b0;
        set_rlevel(5'd0, 7);
        rtick(); rtick();
        check("R10 empty offset unchanged", almost_empty_n, 0);
        set_wlevel(5'd0, 9);
        wtick(); wtick();
        check("R10 full offset unchanged", almost_full_n, 0);
    endtask

    initial begin
        t_reset();
        t_defaults();
        t_load();
        t_seq_home();
        t_almost_empty();
        t_almost_full();
        t_gate_prog();
        t_dual_enable();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule